// File: doc/BRIEF.md
# SPI Command and Data Queue Front End

This block sits between a register interface and the serial engine of an SPI master. Software pushes frames as 32-bit words. The upper half of each word is a command (chip-select pattern, continuation and similar fields) and the lower half is the transmit data. The two halves go into a command queue and a transmit queue in the same cycle. The engine sees the oldest command together with its data. It takes a frame with a one-cycle strobe. Frames that the engine receives go into a receive queue, and software pops them through a registered read port.

In extended mode, software can also write 16-bit halves to a command address and a data address independently. When the wide-frame option is also active, each command owns two data entries: the first entry is the low half and the second is the high half. This supports frames wider than 16 bits. Level flags report space and content in the queues. Two sticky flags record transmit underflow and receive overflow, and writing a one to a flag's clear bit clears it. Separate flush strobes empty the transmit side (command and data together) and the receive side.

Top module: `spi_cmdq_frontend`

## Requirements
- R1: After reset all queues are empty: tx_fill_rdy=1, cmd_fill_rdy=1, rx_drain_rdy=0, tx_uf=0, rx_of=0, eng_cmd_valid=0, pop_data=0.
- R2: A word push (word_en) stores word_data[31:16] as a command and word_data[15:0] as transmit data. From the next cycle the oldest pair appears on eng_cmd and eng_data[15:0].
- R3: Each queue holds DEPTH (4) entries in arrival order. A fill-ready flag is low exactly when its queue is full. A write to a full queue is dropped. A word push is dropped whole when either the command queue or the transmit queue is full.
- R4: Halfword writes (hw_en) are accepted only when ext_mode=1. hw_sel=0 pushes hw_data as a command and hw_sel=1 pushes it as transmit data. When ext_mode=0 they are ignored. A word push in the same cycle takes precedence over a halfword write.
- R5: When ext_mode=1 and frame_wide=1, eng_data shows {second data entry, first data entry}, and a take removes one command and two data entries.
- R6: A take while a command is present but fewer data entries remain than the frame needs sets tx_uf. The command and whatever data is available are removed, and the missing halves read as zero on eng_data.
- R7: Received frames (rx_frame_en) are queued, and pop_en loads the oldest one into pop_data on the next cycle. rx_drain_rdy is high whenever the receive queue is not empty. A pop from an empty queue leaves pop_data unchanged.
- R8: A frame arriving while the receive queue holds DEPTH entries is discarded and sets rx_of.
- R9: flush_tx empties the command and transmit queues, and flush_rx empties the receive queue. Both may be given together. A flush overrides any push, take or frame in the same cycle.
- R10: flag_clr[0] clears tx_uf and flag_clr[1] clears rx_of. Each flag stays set until cleared. A new event in the same cycle as a clear leaves the flag set.
- R11: A take while no command is queued changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_mode | input | 1 | Enables halfword command/data writes |
| frame_wide | input | 1 | With ext_mode, each command uses two data entries |
| word_en | input | 1 | 32-bit push strobe |
| word_data | input | 32 | Command in upper half, data in lower half |
| hw_en | input | 1 | Halfword write strobe |
| hw_sel | input | 1 | 0 = command address, 1 = data address |
| hw_data | input | 16 | Halfword write value |
| flush_tx | input | 1 | Empty command and transmit queues |
| flush_rx | input | 1 | Empty receive queue |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 underflow, bit 1 overflow |
| pop_en | input | 1 | Pop one received frame |
| pop_data | output | 32 | Last popped received frame |
| tx_fill_rdy | output | 1 | Transmit queue has space |
| cmd_fill_rdy | output | 1 | Command queue has space |
| rx_drain_rdy | output | 1 | Receive queue holds data |
| tx_uf | output | 1 | Sticky transmit underflow |
| rx_of | output | 1 | Sticky receive overflow |
| eng_cmd_valid | output | 1 | A command is available to the engine |
| eng_cmd | output | 16 | Oldest command |
| eng_data | output | 32 | Data for the oldest command |
| eng_take | input | 1 | Engine consumes the current frame |
| rx_frame_en | input | 1 | Engine delivers a received frame |
| rx_frame | input | 32 | Received frame value |

## Verification
A pointer or count that drifts inside a queue shows up on eng_cmd, eng_data or pop_data within one take or pop. It shows up as a value out of order, a stale value, or a missing value. An off-by-one in the full test shows up as a fill flag changing at the wrong occupancy, or as a fifth frame that appears after four takes. If the data queue loses lock-step with the command queue, the next frame shows the wrong data half. If the command queue and data queue fall out of step in wide mode, eng_data shows the wrong halves in its upper and lower parts on the very next frame.

// File: rtl/spi_cmdq_pkg.sv
package spi_cmdq_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;
  localparam int FLAG_UF = 0;
  localparam int FLAG_OF = 1;
  localparam int NFLAGS  = 2;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic [1:0]    pop_num,
  output logic [W-1:0]  head0,
  output logic [W-1:0]  head1,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] pop_req, pop_eff;
  logic          do_push;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p, input logic [CW-1:0] n);
    int s;
    s = int'(p) + int'(n);
    if (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign head0 = mem[rd_q];
  assign head1 = mem[adv(rd_q, CW'(1))];

  always_comb begin
    do_push = push && !full;
    pop_req = CW'(pop_num);
    pop_eff = (pop_req > cnt_q) ? cnt_q : pop_req;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      wr_d  = adv(wr_q, CW'(do_push));
      rd_d  = adv(rd_q, pop_eff);
      cnt_d = cnt_q + CW'(do_push) - pop_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_q] <= push_data;
  end

endmodule

// File: rtl/cmdq_ingress.sv
module cmdq_ingress
  import spi_cmdq_pkg::*;
(
  input  logic  ext_mode,
  input  logic  word_en,
  input  word_t word_data,
  input  logic  hw_en,
  input  logic  hw_sel,
  input  half_t hw_data,
  input  logic  cmd_full,
  input  logic  tx_full,
  output logic  cmd_push,
  output half_t cmd_push_data,
  output logic  tx_push,
  output half_t tx_push_data
);

  logic pair_ok;

  always_comb begin
    pair_ok       = !cmd_full && !tx_full;
    cmd_push      = 1'b0;
    tx_push       = 1'b0;
    cmd_push_data = word_data[WORD_W-1:HALF_W];
    tx_push_data  = word_data[HALF_W-1:0];
    if (word_en) begin
      cmd_push = pair_ok;
      tx_push  = pair_ok;
    end else if (hw_en && ext_mode) begin
      cmd_push_data = hw_data;
      tx_push_data  = hw_data;
      if (hw_sel) tx_push  = 1'b1;
      else        cmd_push = 1'b1;
    end
  end

endmodule

// File: rtl/cmdq_dispatch.sv
module cmdq_dispatch
  import spi_cmdq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          ext_mode,
  input  logic          frame_wide,
  input  logic          eng_take,
  input  logic          flush,
  input  logic          cmd_empty,
  input  half_t         cmd_head,
  input  logic [CW-1:0] tx_count,
  input  half_t         tx_head0,
  input  half_t         tx_head1,
  output logic          eng_cmd_valid,
  output half_t         eng_cmd,
  output word_t         eng_data,
  output logic [1:0]    cmd_pop_num,
  output logic [1:0]    tx_pop_num,
  output logic          uf_evt
);

  logic          wide, fire;
  logic [CW-1:0] need, have;
  half_t         lo, hi;

  always_comb begin
    wide          = ext_mode && frame_wide;
    need          = wide ? CW'(2) : CW'(1);
    have          = (tx_count >= need) ? need : tx_count;
    fire          = eng_take && !cmd_empty && !flush;
    cmd_pop_num   = fire ? 2'd1 : 2'd0;
    tx_pop_num    = fire ? have[1:0] : 2'd0;
    uf_evt        = fire && (tx_count < need);
    lo            = (tx_count >= CW'(1)) ? tx_head0 : '0;
    hi            = (wide && tx_count >= CW'(2)) ? tx_head1 : '0;
    eng_cmd_valid = !cmd_empty;
    eng_cmd       = cmd_empty ? '0 : cmd_head;
    eng_data      = {hi, lo};
  end

endmodule

// File: rtl/cmdq_sticky.sv
module cmdq_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);

  logic [N-1:0] flags_q, flags_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb flags_d[i] = set[i] || (flags_q[i] && !clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flags_d[i];
    end
  end

  assign flags = flags_q;

endmodule

// File: rtl/spi_cmdq_frontend.sv
module spi_cmdq_frontend
  import spi_cmdq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mode,
  input  logic        frame_wide,
  input  logic        word_en,
  input  logic [31:0] word_data,
  input  logic        hw_en,
  input  logic        hw_sel,
  input  logic [15:0] hw_data,
  input  logic        flush_tx,
  input  logic        flush_rx,
  input  logic [1:0]  flag_clr,
  input  logic        pop_en,
  output logic [31:0] pop_data,
  output logic        tx_fill_rdy,
  output logic        cmd_fill_rdy,
  output logic        rx_drain_rdy,
  output logic        tx_uf,
  output logic        rx_of,
  output logic        eng_cmd_valid,
  output logic [15:0] eng_cmd,
  output logic [31:0] eng_data,
  input  logic        eng_take,
  input  logic        rx_frame_en,
  input  logic [31:0] rx_frame
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic          cmd_push, tx_push;
  half_t         cmd_push_data, tx_push_data;
  logic          cmd_full, cmd_empty, tx_full, tx_empty;
  half_t         cmd_head, cmd_head1_unused, tx_head0, tx_head1;
  logic [CW-1:0] cmd_count, tx_count;
  logic [1:0]    cmd_pop_num, tx_pop_num;
  logic          uf_evt;

  cmdq_ingress u_ingress (
    .ext_mode      (ext_mode),
    .word_en       (word_en),
    .word_data     (word_data),
    .hw_en         (hw_en),
    .hw_sel        (hw_sel),
    .hw_data       (hw_data),
    .cmd_full      (cmd_full),
    .tx_full       (tx_full),
    .cmd_push      (cmd_push),
    .cmd_push_data (cmd_push_data),
    .tx_push       (tx_push),
    .tx_push_data  (tx_push_data)
  );

  cmdq_fifo #(.W(HALF_W), .DEPTH(DEPTH)) u_cmd_q (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .flush     (flush_tx),
    .push      (cmd_push),
    .push_data (cmd_push_data),
    .pop_num   (cmd_pop_num),
    .head0     (cmd_head),
    .head1     (cmd_head1_unused),
    .count     (cmd_count),
    .full      (cmd_full),
    .empty     (cmd_empty)
  );

  cmdq_fifo #(.W(HALF_W), .DEPTH(DEPTH)) u_tx_q (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .flush     (flush_tx),
    .push      (tx_push),
    .push_data (tx_push_data),
    .pop_num   (tx_pop_num),
    .head0     (tx_head0),
    .head1     (tx_head1),
    .count     (tx_count),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  cmdq_dispatch #(.DEPTH(DEPTH)) u_dispatch (
    .ext_mode      (ext_mode),
    .frame_wide    (frame_wide),
    .eng_take      (eng_take),
    .flush         (flush_tx),
    .cmd_empty     (cmd_empty),
    .cmd_head      (cmd_head),
    .tx_count      (tx_count),
    .tx_head0      (tx_head0),
    .tx_head1      (tx_head1),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_cmd       (eng_cmd),
    .eng_data      (eng_data),
    .cmd_pop_num   (cmd_pop_num),
    .tx_pop_num    (tx_pop_num),
    .uf_evt        (uf_evt)
  );

  logic          rx_push, rx_full, rx_empty, of_evt, rx_pop;
  word_t         rx_head0, rx_head1_unused;
  logic [CW-1:0] rx_count;

  always_comb begin
    rx_push = rx_frame_en && !flush_rx && !rx_full;
    of_evt  = rx_frame_en && !flush_rx && rx_full;
    rx_pop  = pop_en && !rx_empty;
  end

  cmdq_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rx_q (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .flush     (flush_rx),
    .push      (rx_push),
    .push_data (rx_frame),
    .pop_num   ({1'b0, rx_pop}),
    .head0     (rx_head0),
    .head1     (rx_head1_unused),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  word_t pop_q, pop_d;

  always_comb pop_d = rx_pop ? rx_head0 : pop_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) pop_q <= '0;
    else             pop_q <= pop_d;
  end

  logic [NFLAGS-1:0] flag_set, flags;

  always_comb begin
    flag_set          = '0;
    flag_set[FLAG_UF] = uf_evt;
    flag_set[FLAG_OF] = of_evt;
  end

  cmdq_sticky #(.N(NFLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_core_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .flags (flags)
  );

  assign pop_data     = pop_q;
  assign tx_fill_rdy  = !tx_full;
  assign cmd_fill_rdy = !cmd_full;
  assign rx_drain_rdy = !rx_empty;
  assign tx_uf        = flags[FLAG_UF];
  assign rx_of        = flags[FLAG_OF];

endmodule

// File: rtl/spi_cmdq_chk.sv
module spi_cmdq_chk #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_core_n,
  input logic          flush_tx,
  input logic          flush_rx,
  input logic [1:0]    flag_clr,
  input logic          pop_en,
  input logic [31:0]   pop_data,
  input logic          rx_drain_rdy,
  input logic          tx_fill_rdy,
  input logic          cmd_fill_rdy,
  input logic          tx_uf,
  input logic          rx_of,
  input logic          rx_frame_en,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          eng_take,
  input logic          eng_cmd_valid,
  input logic          word_en,
  input logic          hw_en
);

  // R8
  rx_of_set_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    rx_frame_en && !flush_rx && rx_count == CW'(DEPTH) |=> rx_of);

  // R10
  of_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    rx_of && !flag_clr[1] |=> rx_of);

  // R10
  uf_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_uf && !flag_clr[0] |=> tx_uf);

  // R7
  pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    pop_en && !rx_drain_rdy |=> $stable(pop_data));

  // R9
  flush_tx_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    flush_tx |=> tx_fill_rdy && cmd_fill_rdy && !eng_cmd_valid);

  // R9
  flush_rx_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    flush_rx |=> !rx_drain_rdy);

  // R6
  uf_set_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    eng_take && eng_cmd_valid && !flush_tx && tx_count == '0 |=> tx_uf);

  // R11
  idle_take_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    eng_take && !eng_cmd_valid && !word_en && !hw_en |=> !eng_cmd_valid);

endmodule

bind spi_cmdq_frontend spi_cmdq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_core_n    (rst_core_n),
  .flush_tx      (flush_tx),
  .flush_rx      (flush_rx),
  .flag_clr      (flag_clr),
  .pop_en        (pop_en),
  .pop_data      (pop_data),
  .rx_drain_rdy  (rx_drain_rdy),
  .tx_fill_rdy   (tx_fill_rdy),
  .cmd_fill_rdy  (cmd_fill_rdy),
  .tx_uf         (tx_uf),
  .rx_of         (rx_of),
  .rx_frame_en   (rx_frame_en),
  .rx_count      (rx_count),
  .tx_count      (tx_count),
  .eng_take      (eng_take),
  .eng_cmd_valid (eng_cmd_valid),
  .word_en       (word_en),
  .hw_en         (hw_en)
);

// File: tb/spi_cmdq_frontend_tb.sv
module spi_cmdq_frontend_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_mode = 0, frame_wide = 0, word_en = 0, hw_en = 0, hw_sel = 0;
  logic [31:0] word_data = '0, rx_frame = '0;
  logic [15:0] hw_data = '0;
  logic flush_tx = 0, flush_rx = 0, pop_en = 0, eng_take = 0, rx_frame_en = 0;
  logic [1:0] flag_clr = '0;
  logic [31:0] pop_data, eng_data;
  logic [15:0] eng_cmd;
  logic tx_fill_rdy, cmd_fill_rdy, rx_drain_rdy, tx_uf, rx_of, eng_cmd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmdq_frontend #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .frame_wide(frame_wide),
    .word_en(word_en), .word_data(word_data), .hw_en(hw_en), .hw_sel(hw_sel),
    .hw_data(hw_data), .flush_tx(flush_tx), .flush_rx(flush_rx),
    .flag_clr(flag_clr), .pop_en(pop_en), .pop_data(pop_data),
    .tx_fill_rdy(tx_fill_rdy), .cmd_fill_rdy(cmd_fill_rdy),
    .rx_drain_rdy(rx_drain_rdy), .tx_uf(tx_uf), .rx_of(rx_of),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd), .eng_data(eng_data),
    .eng_take(eng_take), .rx_frame_en(rx_frame_en), .rx_frame(rx_frame)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    word_en = 0; hw_en = 0; flush_tx = 0; flush_rx = 0; flag_clr = '0;
    pop_en = 0; eng_take = 0; rx_frame_en = 0;
  endtask

  task automatic push_word(input logic [31:0] w);
    word_en = 1; word_data = w; step();
  endtask

  task automatic push_half(input logic sel, input logic [15:0] v);
    hw_en = 1; hw_sel = sel; hw_data = v; step();
  endtask

  task automatic take();
    eng_take = 1; step();
  endtask

  task automatic clean();
    flush_tx = 1; flush_rx = 1; flag_clr = 2'b11; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 flags", {27'd0, tx_fill_rdy, cmd_fill_rdy, rx_drain_rdy, tx_uf, rx_of}, 32'b11000);
    check("R1 cmd_valid", {31'd0, eng_cmd_valid}, 32'd0);
    check("R1 pop_data", pop_data, 32'd0);

    // R2 R3 word push sweep, six pushes into depth four
    for (int n = 1; n <= 6; n++) begin
      push_word({16'hC000 + 16'(n), 16'hD000 + 16'(n)});
      check("R3 tx_fill_rdy", {31'd0, tx_fill_rdy}, {31'd0, (n < DEPTH)});
      check("R3 cmd_fill_rdy", {31'd0, cmd_fill_rdy}, {31'd0, (n < DEPTH)});
      check("R2 head cmd", {16'd0, eng_cmd}, 32'h0000C001);
    end
    for (int k = 1; k <= DEPTH; k++) begin
      check("R2 eng_cmd order", {16'd0, eng_cmd}, {16'd0, 16'hC000 + 16'(k)});
      check("R2 eng_data order", eng_data, {16'd0, 16'hD000 + 16'(k)});
      take();
    end
    check("R3 dropped pushes absent", {31'd0, eng_cmd_valid}, 32'd0);
    check("R2 no underflow", {31'd0, tx_uf}, 32'd0);

    // R3 word push dropped whole when only the data queue is full
    ext_mode = 1;
    for (int k = 0; k < DEPTH; k++) push_half(1'b1, 16'hE000 + 16'(k));
    push_word(32'h1234_5678);
    check("R3 pair dropped", {31'd0, eng_cmd_valid}, 32'd0);
    check("R3 tx full", {31'd0, tx_fill_rdy}, 32'd0);
    clean();

    // R4 halfword writes ignored outside extended mode
    ext_mode = 0;
    push_half(1'b0, 16'hAAAA);
    check("R4 cmd ignored", {31'd0, eng_cmd_valid}, 32'd0);
    push_half(1'b1, 16'hBBBB);
    push_word(32'h0101_0202);
    check("R4 data ignored", eng_data, 32'h0000_0202);
    check("R4 cmd via word", {16'd0, eng_cmd}, 32'h0000_0101);
    clean();
    // R4 extended mode halfword writes and word precedence
    ext_mode = 1;
    push_half(1'b0, 16'hA1A1);
    push_half(1'b1, 16'hB1B1);
    check("R4 ext cmd", {16'd0, eng_cmd}, 32'h0000_A1A1);
    check("R4 ext data", eng_data, 32'h0000_B1B1);
    take();
    word_en = 1; word_data = 32'h3333_4444; hw_en = 1; hw_sel = 1'b0; hw_data = 16'h9999; step();
    check("R4 word wins", {16'd0, eng_cmd}, 32'h0000_3333);
    take();
    check("R4 no extra cmd", {31'd0, eng_cmd_valid}, 32'd0);
    clean();

    // R5 wide frames
    frame_wide = 1;
    for (int f = 0; f < 2; f++) begin
      push_half(1'b0, 16'h7000 + 16'(f));
      push_half(1'b1, 16'h1000 + 16'(f));
      push_half(1'b1, 16'h2000 + 16'(f));
    end
    for (int f = 0; f < 2; f++) begin
      check("R5 wide cmd", {16'd0, eng_cmd}, {16'd0, 16'h7000 + 16'(f)});
      check("R5 wide data", eng_data, {16'h2000 + 16'(f), 16'h1000 + 16'(f)});
      take();
    end
    check("R5 no underflow", {31'd0, tx_uf}, 32'd0);
    check("R5 drained", {31'd0, eng_cmd_valid}, 32'd0);

    // R6 underflow sweep over available data entries
    for (int avail = 0; avail <= 2; avail++) begin
      clean();
      push_half(1'b0, 16'h5A00 + 16'(avail));
      for (int d = 0; d < avail; d++) push_half(1'b1, 16'h4000 + 16'(d));
      check("R6 partial data", eng_data,
            {(avail >= 2) ? 16'h4001 : 16'h0, (avail >= 1) ? 16'h4000 : 16'h0});
      take();
      check("R6 uf flag", {31'd0, tx_uf}, {31'd0, (avail < 2)});
      check("R6 cmd removed", {31'd0, eng_cmd_valid}, 32'd0);
      push_half(1'b0, 16'h6600);
      push_half(1'b1, 16'h6611);
      push_half(1'b1, 16'h6622);
      check("R6 leftovers removed", eng_data, 32'h6622_6611);
    end
    // R6 narrow underflow
    clean();
    frame_wide = 0;
    push_half(1'b0, 16'h0F0F);
    take();
    check("R6 narrow uf", {31'd0, tx_uf}, 32'd1);

    // R10 clear, and set wins over clear
    flag_clr = 2'b10; step();
    check("R10 other clear no effect", {31'd0, tx_uf}, 32'd1);
    flag_clr = 2'b01; step();
    check("R10 uf cleared", {31'd0, tx_uf}, 32'd0);
    push_half(1'b0, 16'h0E0E);
    eng_take = 1; flag_clr = 2'b01; step();
    check("R10 set wins", {31'd0, tx_uf}, 32'd1);
    clean();

    // R11 take with no command
    push_half(1'b1, 16'hBEEF);
    take();
    check("R11 no uf", {31'd0, tx_uf}, 32'd0);
    push_half(1'b0, 16'hCAFE);
    check("R11 data kept", eng_data, 32'h0000_BEEF);
    clean();

    // R7 R8 receive sweep
    for (int n = 0; n <= 6; n++) begin
      clean();
      for (int f = 0; f < n; f++) begin
        rx_frame_en = 1; rx_frame = 32'h5500_0000 + 32'(n * 16 + f); step();
      end
      check("R7 drain rdy", {31'd0, rx_drain_rdy}, {31'd0, (n > 0)});
      check("R8 overflow", {31'd0, rx_of}, {31'd0, (n > DEPTH)});
      for (int f = 0; f < ((n < DEPTH) ? n : DEPTH); f++) begin
        pop_en = 1; step();
        check("R7 pop order", pop_data, 32'h5500_0000 + 32'(n * 16 + f));
      end
      if (n > 0) begin
        pop_en = 1; step();
        check("R7 empty pop holds", pop_data,
              32'h5500_0000 + 32'(n * 16 + ((n < DEPTH) ? n : DEPTH) - 1));
        check("R7 drained", {31'd0, rx_drain_rdy}, 32'd0);
      end
    end
    flag_clr = 2'b10; step();
    check("R10 of cleared", {31'd0, rx_of}, 32'd0);

    // R9 joint flush, and flush wins over same-cycle writes
    push_word(32'h1111_2222);
    rx_frame_en = 1; rx_frame = 32'h77; step();
    flush_tx = 1; flush_rx = 1; word_en = 1; word_data = 32'h9999_8888;
    rx_frame_en = 1; rx_frame = 32'h66; step();
    check("R9 tx flushed", {31'd0, eng_cmd_valid}, 32'd0);
    check("R9 rx flushed", {31'd0, rx_drain_rdy}, 32'd0);
    check("R9 fill rdy", {30'd0, tx_fill_rdy, cmd_fill_rdy}, 32'b11);
    rx_frame_en = 1; rx_frame = 32'h55; step();
    flush_rx = 1; step();
    check("R9 rx only", {31'd0, rx_drain_rdy}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule